// File: doc/BRIEF.md
# Oscillator-Timed Power-Up and Output Enable Sequencer

This block controls power-up and the operating mode of a receiver front-end. It runs on the crystal-oscillator clock. A rising edge on the chip-enable pin starts it. A single up-counter measures two windows after that edge. The short window sets when the buffered crystal-clock output may turn on. The long window is an internal reset, and the configuration defaults are loaded while it lasts. The defaults depend on a strap pin.

Once the internal reset ends, the final output enables come from the register fields and the pins. The pins are chip-enable, RF-enable and the strap. The outputs are the RF-chain enable, the crystal-clock buffer enable and the sample-clock buffer enable. A register write to the enable field takes control of the buffers away from the pins. That control stays with the registers until the next power-up.

The sample clock comes from one of two sources: the oscillator itself, or a VCO clock divided by a parameter (96 by default). The change between sources is glitch-free. Every disabled clock output is driven low.

Top module: `osc_pwr_seq`

## Requirements
- R1: While `chip_en` is low, `xclk_oe`, `gclk_oe`, `rf_on`, `xclk_out` and `gclk_out` are all low, and `cfg_rst` is high.
- R2: After `chip_en` rises, `cfg_rst` stays high through the (RST_CYC-1)-th following rising edge of `osc_clk` and is low from the RST_CYC-th edge on.
- R3: While `cfg_rst` is high, `gclk_oe` and `rf_on` are low, and `xclk_oe` is high exactly when `strap` is 1 and at least CKOE_CYC edges have passed since `chip_en` rose.
- R4: The internal reset loads the defaults. With `strap`=0 these are N=96, R=1, MST=0, XCE=0. With `strap`=1 they are N=1555, R=19, MST=1, XCE=1. For both straps GCE=1, ENM=1 and RFE=0.
- R5: After reset, with `rf_en_pin` low and no enable-field write made, only one buffer is on: `xclk_oe`=`strap` and `gclk_oe`=!`strap`. `rf_on` is low.
- R6: After reset, `rf_on` = ENM and (`rf_en_pin` or RFE). With `rf_en_pin` high the buffers follow GCE and XCE, so with `strap`=0 the crystal-clock output stays off.
- R7: A write with `wr_sel`=0 loads the enable field. The bits are ENM at bit 0, RFE at bit 1, GCE at bit 2, XCE at bit 3 and MST at bit 4. From then on `xclk_oe`=XCE and `gclk_oe`=GCE whatever `rf_en_pin` is. This lasts until `chip_en` rises again, which restores the strap behaviour.
- R8: Writes made while `cfg_rst` is high have no effect. Writes with `wr_sel`=3 have no effect.
- R9: A write with `wr_sel`=1 stages N from `wr_data[11:0]` and does not change the `ndiv` output. A write with `wr_sel`=2 loads R from `wr_data[5:0]` and makes `ndiv` and `rdiv` change together in the same cycle.
- R10: `xclk_out` equals `osc_clk` while `xclk_oe` is high and is low otherwise. `gclk_out` is low while `gclk_oe` is low.
- R11: With MST=1, `sample_src` becomes 1 and `gclk_out` is `vco_clk` divided by VCO_DIV with a high phase of VCO_DIV/2 VCO cycles. With MST=0 it is `osc_clk`. The source changes only at a falling `osc_clk` edge while the divided clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Crystal-oscillator clock |
| vco_clk | input | 1 | VCO clock feeding the divider |
| chip_en | input | 1 | Chip enable; low means stand-by; its rising edge starts the sequence |
| rf_en_pin | input | 1 | RF-chain enable pin |
| strap | input | 1 | Default-configuration strap |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 enables, 1 N stage, 2 R and commit, 3 none |
| wr_data | input | 12 | Write data |
| xclk_out | output | 1 | Gated crystal-clock output |
| gclk_out | output | 1 | Gated sample-clock output |
| xclk_oe | output | 1 | Crystal-clock buffer enable |
| gclk_oe | output | 1 | Sample-clock buffer enable |
| rf_on | output | 1 | RF-chain enable |
| cfg_rst | output | 1 | Internal reset active |
| sample_src | output | 1 | Current sample-clock source (1 = divided VCO) |
| ndiv | output | 12 | Feedback divider ratio |
| rdiv | output | 6 | Reference divider ratio |

## Verification
A wrong count in the window counter shows at the ports within one oscillator cycle. `cfg_rst` falls on the wrong edge, or `xclk_oe` rises early or late. A stale override flag or a wrong default shows as soon as the internal reset ends, through the buffer enables and the divider outputs. A broken divider or source select changes the high time of `gclk_out` within one divided period. So does a stuck select bit.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;
  localparam int unsigned NDIV_W = 12;
  localparam int unsigned RDIV_W = 6;

  typedef struct packed {
    logic              mst;
    logic              xce;
    logic              gce;
    logic              rfe;
    logic              enm;
    logic [NDIV_W-1:0] ndiv;
    logic [RDIV_W-1:0] rdiv;
  } cfg_t;

  // Strap-selected configuration loaded during the internal reset
  function automatic cfg_t strap_defaults(input logic strap);
    cfg_t c;
    c.mst  = strap;
    c.xce  = strap;
    c.gce  = 1'b1;
    c.rfe  = 1'b0;
    c.enm  = 1'b1;
    c.ndiv = strap ? NDIV_W'(1555) : NDIV_W'(96);
    c.rdiv = strap ? RDIV_W'(19)   : RDIV_W'(1);
    return c;
  endfunction

  // Buffer enables after reset: {xclk, gclk}
  function automatic logic [1:0] buf_enables(input logic regs_rule, input logic strap,
                                             input logic xce, input logic gce);
    return regs_rule ? {xce, gce} : {strap, ~strap};
  endfunction
endpackage

// File: rtl/osc_seq_timer.sv
module osc_seq_timer #(
  parameter int unsigned CKOE_CYC = 17,
  parameter int unsigned RST_CYC  = 65472
) (
  input  logic osc_clk,
  input  logic chip_en,
  output logic ckoe_ok,
  output logic in_rst
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge osc_clk or negedge chip_en) begin
    if (!chip_en)                  cnt_q <= '0;
    else if (cnt_q != CW'(RST_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign ckoe_ok = (cnt_q >= CW'(CKOE_CYC));
  assign in_rst  = (cnt_q <  CW'(RST_CYC));
endmodule

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs
  import osc_seq_pkg::*;
(
  input  logic        osc_clk,
  input  logic        chip_en,
  input  logic        strap,
  input  logic        in_rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [11:0] wr_data,
  output cfg_t        cfg,
  output logic        ovr_seen
);
  cfg_t              cfg_q;
  cfg_t              dflt;
  logic [NDIV_W-1:0] ndiv_stage;
  logic              ovr_q;

  always_comb dflt = strap_defaults(strap);

  always_ff @(posedge osc_clk or negedge chip_en) begin
    if (!chip_en) begin
      cfg_q      <= '0;
      ndiv_stage <= '0;
      ovr_q      <= 1'b0;
    end else if (in_rst) begin
      cfg_q      <= dflt;
      ndiv_stage <= dflt.ndiv;
      ovr_q      <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          cfg_q.enm <= wr_data[0];
          cfg_q.rfe <= wr_data[1];
          cfg_q.gce <= wr_data[2];
          cfg_q.xce <= wr_data[3];
          cfg_q.mst <= wr_data[4];
          ovr_q     <= 1'b1;
        end
        2'd1: ndiv_stage <= wr_data[NDIV_W-1:0];
        2'd2: begin
          cfg_q.rdiv <= wr_data[RDIV_W-1:0];
          cfg_q.ndiv <= ndiv_stage;
        end
        default: ;
      endcase
    end
  end

  assign cfg      = cfg_q;
  assign ovr_seen = ovr_q;
endmodule

// File: rtl/osc_clk_src_sel.sv
module osc_clk_src_sel #(
  parameter int unsigned VCO_DIV = 96
) (
  input  logic osc_clk,
  input  logic vco_clk,
  input  logic chip_en,
  input  logic mst_req,
  output logic lo_div,
  output logic src_sel,
  output logic clk_mux
);
  localparam int unsigned HALF = VCO_DIV / 2;
  localparam int unsigned CW   = $clog2(HALF);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge vco_clk or negedge chip_en) begin
    if (!chip_en) begin
      div_cnt <= '0;
      lo_div  <= 1'b0;
    end else if (div_cnt == CW'(HALF - 1)) begin
      div_cnt <= '0;
      lo_div  <= ~lo_div;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // At a falling oscillator edge the oscillator is low; switch only if the divided clock is too
  always_ff @(negedge osc_clk or negedge chip_en) begin
    if (!chip_en)                            src_sel <= 1'b0;
    else if ((mst_req != src_sel) && !lo_div) src_sel <= mst_req;
  end

  assign clk_mux = src_sel ? lo_div : osc_clk;
endmodule

// File: rtl/osc_pwr_seq.sv
module osc_pwr_seq
  import osc_seq_pkg::*;
#(
  parameter int unsigned CKOE_CYC = 17,
  parameter int unsigned RST_CYC  = 65472,
  parameter int unsigned VCO_DIV  = 96
) (
  input  logic        osc_clk,
  input  logic        vco_clk,
  input  logic        chip_en,
  input  logic        rf_en_pin,
  input  logic        strap,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [11:0] wr_data,
  output logic        xclk_out,
  output logic        gclk_out,
  output logic        xclk_oe,
  output logic        gclk_oe,
  output logic        rf_on,
  output logic        cfg_rst,
  output logic        sample_src,
  output logic [11:0] ndiv,
  output logic [5:0]  rdiv
);
  logic       ckoe_ok, in_rst, ovr_seen, lo_div, src_sel, clk_mux;
  cfg_t       cfg;
  logic [1:0] run_bufs;

  osc_seq_timer #(.CKOE_CYC(CKOE_CYC), .RST_CYC(RST_CYC)) timer_i (
    .osc_clk(osc_clk), .chip_en(chip_en), .ckoe_ok(ckoe_ok), .in_rst(in_rst)
  );

  osc_cfg_regs regs_i (
    .osc_clk(osc_clk), .chip_en(chip_en), .strap(strap), .in_rst(in_rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg(cfg), .ovr_seen(ovr_seen)
  );

  osc_clk_src_sel #(.VCO_DIV(VCO_DIV)) src_i (
    .osc_clk(osc_clk), .vco_clk(vco_clk), .chip_en(chip_en), .mst_req(cfg.mst),
    .lo_div(lo_div), .src_sel(src_sel), .clk_mux(clk_mux)
  );

  assign run_bufs = buf_enables(ovr_seen || rf_en_pin, strap, cfg.xce, cfg.gce);

  assign xclk_oe    = chip_en && (in_rst ? (ckoe_ok && strap) : run_bufs[1]);
  assign gclk_oe    = chip_en && !in_rst && run_bufs[0];
  assign rf_on      = chip_en && !in_rst && cfg.enm && (rf_en_pin || cfg.rfe);
  assign cfg_rst    = in_rst;
  assign sample_src = src_sel;
  assign ndiv       = cfg.ndiv;
  assign rdiv       = cfg.rdiv;
  assign xclk_out   = xclk_oe & osc_clk;
  assign gclk_out   = gclk_oe & clk_mux;
endmodule

// File: rtl/osc_pwr_seq_chk.sv
module osc_pwr_seq_chk (
  input logic        osc_clk,
  input logic        chip_en,
  input logic        strap,
  input logic        in_rst,
  input logic        xclk_oe,
  input logic        gclk_oe,
  input logic        rf_on,
  input logic        xclk_out,
  input logic [11:0] ndiv,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic        lo_div,
  input logic        src_sel
);
  always @(posedge osc_clk) begin
    if (!chip_en) begin
      p_standby_quiet_r1: assert (!xclk_oe && !gclk_oe && !rf_on && in_rst);
    end
  end

  p_quiet_in_reset_r3: assert property (@(posedge osc_clk) disable iff (!chip_en)
    in_rst |-> (!gclk_oe && !rf_on));

  p_early_clk_strap_r3: assert property (@(posedge osc_clk) disable iff (!chip_en)
    (in_rst && xclk_oe) |-> strap);

  p_rf_after_reset_r6: assert property (@(posedge osc_clk) disable iff (!chip_en)
    rf_on |-> !in_rst);

  p_xclk_gated_r10: assert property (@(posedge osc_clk) disable iff (!chip_en)
    !xclk_oe |-> !xclk_out);

  p_div_commit_r9: assert property (@(posedge osc_clk) disable iff (!chip_en)
    (ndiv != $past(ndiv)) |-> ($past(in_rst) || $past(wr_en && wr_sel == 2'd2)));

  p_switch_low_r11: assert property (@(negedge osc_clk) disable iff (!chip_en)
    (src_sel != $past(src_sel)) |-> !$past(lo_div));
endmodule

bind osc_pwr_seq osc_pwr_seq_chk chk_i (
  .osc_clk(osc_clk), .chip_en(chip_en), .strap(strap), .in_rst(in_rst),
  .xclk_oe(xclk_oe), .gclk_oe(gclk_oe), .rf_on(rf_on), .xclk_out(xclk_out),
  .ndiv(ndiv), .wr_en(wr_en), .wr_sel(wr_sel), .lo_div(lo_div), .src_sel(src_sel)
);

// File: tb/osc_pwr_seq_tb.sv
`timescale 1ns/1ps
module osc_pwr_seq_tb_top;
  localparam int CKOE = 3;
  localparam int RST  = 12;
  localparam int VDIV = 8;

  logic        osc_clk = 1'b0, vco_clk = 1'b0;
  logic        chip_en = 1'b0, rf_en_pin = 1'b0, strap = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [11:0] wr_data = '0;
  logic        xclk_out, gclk_out, xclk_oe, gclk_oe, rf_on, cfg_rst, sample_src;
  logic [11:0] ndiv;
  logic [5:0]  rdiv;

  int checks = 0, fails = 0;

  always #5 osc_clk = ~osc_clk;
  always #1 vco_clk = ~vco_clk;

  osc_pwr_seq #(.CKOE_CYC(CKOE), .RST_CYC(RST), .VCO_DIV(VDIV)) dut_i (
    .osc_clk(osc_clk), .vco_clk(vco_clk), .chip_en(chip_en), .rf_en_pin(rf_en_pin),
    .strap(strap), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xclk_out(xclk_out), .gclk_out(gclk_out), .xclk_oe(xclk_oe), .gclk_oe(gclk_oe),
    .rf_on(rf_on), .cfg_rst(cfg_rst), .sample_src(sample_src), .ndiv(ndiv), .rdiv(rdiv)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic hi_sample();
    @(posedge osc_clk); #3;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [11:0] d);
    @(negedge osc_clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge osc_clk);
    wr_en = 1'b0;
  endtask

  // Power-up with a rejected write inside the reset window (R8)
  task automatic power_up(input logic s, input logic r);
    @(negedge osc_clk);
    chip_en = 1'b0; strap = s; rf_en_pin = r;
    hi_sample();
    chk("R1 standby", {xclk_oe, gclk_oe, rf_on, xclk_out, gclk_out, cfg_rst}, 6'b000001);
    @(negedge osc_clk);
    chip_en = 1'b1;
    for (int k = 1; k <= RST + 1; k++) begin
      hi_sample();
      chk("R2 reset window", cfg_rst, (k < RST) ? 1 : 0);
      if (k < RST) begin
        chk("R3 early enable", {xclk_oe, gclk_oe, rf_on}, {(s && k >= CKOE), 2'b00});
        chk("R10 gating", {xclk_out, gclk_out}, {xclk_oe, 1'b0});
      end
      if (k == 2) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = 12'h000; end
      if (k == 3) wr_en = 1'b0;
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    // Sweep strap and RF-enable pin
    for (int s = 0; s < 2; s++) begin
      for (int r = 0; r < 2; r++) begin
        power_up(s[0], r[0]);
        chk("R4 ndiv default", ndiv, s ? 1555 : 96);
        chk("R4 rdiv default", rdiv, s ? 19 : 1);
        chk("R8 write in reset ignored", rf_on, r);
        if (r == 0) begin
          chk("R5 clock-only", {xclk_oe, gclk_oe, rf_on}, {s[0], ~s[0], 1'b0});
        end else begin
          chk("R6 full mode", {xclk_oe, gclk_oe, rf_on}, {s[0], 1'b1, 1'b1});
        end
        chk("R10 xclk out", xclk_out, xclk_oe);
      end
    end

    // Override with strap 0, pin low
    power_up(1'b0, 1'b0);
    wr(2'd0, 12'h00B);             // enm=1 rfe=1 gce=0 xce=1 mst=0
    hi_sample();
    chk("R7 override", {xclk_oe, gclk_oe, rf_on}, 3'b101);
    chk("R10 gclk low when off", gclk_out, 0);
    rf_en_pin = 1'b1;
    wr(2'd0, 12'h00A);             // enm=0 rfe=1 gce=0 xce=1
    hi_sample();
    chk("R6 enm gates rf", rf_on, 0);
    rf_en_pin = 1'b0;
    wr(2'd3, 12'hFFF);
    hi_sample();
    chk("R8 sel3 ignored", {xclk_oe, gclk_oe, rf_on, ndiv, rdiv}, {3'b100, 12'd96, 6'd1});
    wr(2'd1, 12'd300);
    hi_sample();
    chk("R9 staged ndiv held", ndiv, 96);
    wr(2'd2, 12'd7);
    hi_sample();
    chk("R9 commit", {ndiv, rdiv}, {12'd300, 6'd7});
    power_up(1'b0, 1'b0);
    chk("R7 override cleared", {xclk_oe, gclk_oe, ndiv}, {2'b01, 12'd96});

    // Sample clock source
    power_up(1'b1, 1'b1);
    repeat (6) @(posedge osc_clk);
    #2;
    chk("R11 vco source", sample_src, 1);
    begin
      int n = 0;
      @(posedge gclk_out); #0.2;
      while (gclk_out && n < 100) begin
        @(posedge vco_clk); #0.2;
        n++;
      end
      chk("R11 divided high time", n, VDIV / 2);
    end
    wr(2'd0, 12'h00D);             // enm=1 rfe=0 gce=1 xce=1 mst=0
    repeat (6) @(posedge osc_clk);
    #2;
    chk("R11 osc source", sample_src, 0);
    chk("R11 gclk follows osc high", gclk_out, 1);
    @(negedge osc_clk); #2;
    chk("R11 gclk follows osc low", gclk_out, 0);

    finish_run();
  end
endmodule